// File: doc/BRIEF.md
# Camera Byte Stream to Video Stream Bridge

The bridge sits between a parallel image sensor and a video DMA write channel. It runs on the sensor's pixel clock and takes the sensor's 8-bit data bus together with the line-active qualifier (`cam_href`) and the frame sync (`cam_vsync`). Every two bytes seen while the line is active form one 16-bit 5-6-5 colour sample. The sample is widened to a 32-bit word with 8 bits per channel and sent out on an AXI4-Stream master.

The stream carries a line-end marker (`m_tlast`) on the last pixel of each line and a frame-start marker (`m_fsync`) on the first pixel after each frame sync. The sensor cannot be paused, so the bridge never waits for `m_tready`. A beat offered while the sink is not ready is lost, and the loss is recorded in a sticky flag that only reset clears. The line length is a parameter whose default is 640 pixels for a 640x480 frame.

Top module: `cam_axis_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, `m_tvalid`, `m_tlast`, `m_fsync` and `overflow` are 0 and `m_tdata` is 0 after that edge.
- R2: Bytes are paired in arrival order while `cam_href` is high. The first byte of a pair is bits 15:8 of the sample and the second is bits 7:0. `m_tvalid` is high for exactly the one cycle after the edge that samples the second byte, and low otherwise.
- R3: For a sample with red in bits 15:11, green in 10:5 and blue in 4:0, `m_tdata` is {8'h00, red, 3'b000, green, 2'b00, blue, 3'b000}.
- R4: `m_tlast` is high with the LINE_PIXELS-th beat of a line (parameter, default 640). The pixel count then restarts at zero.
- R5: `m_fsync` is high with the first beat after a rising edge of `cam_vsync`, and on no other beat of that frame.
- R6: A rising edge of `cam_vsync` clears the pixel count of the line, so the LINE_PIXELS-th beat after it carries `m_tlast`.
- R7: A low `cam_href` discards any half-received pair. The next byte taken after `cam_href` returns is a first byte.
- R8: `m_tready` has no effect on the beat timing. If `m_tvalid` is high while `m_tready` is low, `overflow` goes high after the next edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock from the sensor |
| rst_n | input | 1 | Synchronous reset, active low |
| cam_vsync | input | 1 | Frame sync; its rising edge starts a frame |
| cam_href | input | 1 | High while line bytes are on the bus |
| cam_data | input | 8 | Sensor data byte |
| m_tready | input | 1 | Sink ready (observed only for overflow) |
| m_tdata | output | 32 | Expanded pixel word |
| m_tvalid | output | 1 | Beat valid, one cycle per pixel |
| m_tlast | output | 1 | Last pixel of a line |
| m_fsync | output | 1 | First pixel of a frame |
| overflow | output | 1 | Sticky flag: a beat was offered without ready |

## Verification
The assertions assume that every input is known after reset and that the sensor keeps `cam_href` low while `cam_vsync` rises. Under those conditions the output flags coincide only with valid beats, and beats can never come back to back. The bench drives every byte half a clock away from the sampling edge and always puts complete pairs on the bus, except in the one case that tests a dropped half-pair. It raises frame sync only while the line qualifier is low. It shortens the line to four pixels so that line ends, counter restarts and mid-line frame syncs all happen within a few dozen cycles.

// File: rtl/cam_stream_pkg.sv
// Package: shared types and the colour-widening function for the
// camera-to-stream bridge. Assumes 5-6-5 input samples, 32-bit output.
package cam_stream_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [4:0] red;
        logic [5:0] green;
        logic [4:0] blue;
    } rgb565_t;

    // Widen each channel to 8 bits by appending zeros, top byte zero.
    function automatic logic [WORD_W-1:0] widen_rgb(input rgb565_t px);
        widen_rgb = {8'h00, px.red, 3'b000, px.green, 2'b00, px.blue, 3'b000};
    endfunction

endpackage

// File: rtl/cam_byte_pairer.sv
// Module: pairs consecutive sensor bytes into one 5-6-5 sample.
// Assumes the first byte of each pair is the high half; a low line
// qualifier or a frame-sync edge drops any half-received pair.
module cam_byte_pairer
    import cam_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_active,
    input  logic              restart,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pair_ready,
    output rgb565_t           pair_data
);

    logic              second_half;
    logic [BYTE_W-1:0] high_byte;

    // Track which half of the pair the next byte is, and keep the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !line_active) begin
            second_half <= 1'b0;
            if (!rst_n) high_byte <= '0;
        end else begin
            second_half <= ~second_half;
            if (!second_half) high_byte <= byte_in;
        end
    end

    // The pair is complete when the second byte is on the bus.
    always_comb begin
        pair_ready = line_active && second_half && !restart;
        pair_data  = rgb565_t'({high_byte, byte_in});
    end

    // R2: a completed pair needs the line qualifier on the previous edge too.
    p_pair_needs_two_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> $past(line_active));

    // R7: after a low qualifier the next byte can not complete a pair.
    p_drop_half_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_active |=> !pair_ready);

endmodule

// File: rtl/cam_line_tracker.sv
// Module: counts pixels per line and arms the frame-start marker.
// Assumes the frame sync rises while the line qualifier is low.
module cam_line_tracker #(
    parameter int LINE_PIXELS = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic pixel_done,
    output logic frame_restart,
    output logic at_line_end,
    output logic at_frame_start
);

    localparam int CNT_W = (LINE_PIXELS > 1) ? $clog2(LINE_PIXELS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINE_PIXELS - 1);

    logic             vsync_q;
    logic [CNT_W-1:0] pix_cnt;
    logic             start_armed;

    // Remember the previous frame-sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync_in;
    end

    assign frame_restart = vsync_in && !vsync_q;

    // Count pixels in the line, wrap at the line length, clear on frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_restart) begin
            pix_cnt <= '0;
        end else if (pixel_done) begin
            pix_cnt <= (pix_cnt == LAST_IDX) ? '0 : pix_cnt + 1'b1;
        end
    end

    // Arm on frame sync, disarm when the first pixel of the frame passes.
    always_ff @(posedge clk) begin
        if (!rst_n)             start_armed <= 1'b0;
        else if (frame_restart) start_armed <= 1'b1;
        else if (pixel_done)    start_armed <= 1'b0;
    end

    assign at_line_end    = pix_cnt == LAST_IDX;
    assign at_frame_start = start_armed;

    // R4: the counter never leaves the line range.
    p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt <= LAST_IDX);

    // R6: a frame-sync edge leaves the counter at zero.
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_restart |=> pix_cnt == '0);

    // R5: a pixel consumes the frame-start marker.
    p_start_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_done && !frame_restart) |=> !start_armed);

endmodule

// File: rtl/cam_stream_out.sv
// Module: registers the output beat and keeps the sticky overflow flag.
// Assumes the sink may stall; beats are never held, only counted as lost.
module cam_stream_out
    import cam_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_in,
    input  rgb565_t           sample_in,
    input  logic              last_in,
    input  logic              first_in,
    input  logic              sink_ready,
    output logic [WORD_W-1:0] tdata,
    output logic              tvalid,
    output logic              tlast,
    output logic              fsync,
    output logic              lost_beat
);

    // Present each completed pixel for one cycle with its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdata  <= '0;
            tvalid <= 1'b0;
            tlast  <= 1'b0;
            fsync  <= 1'b0;
        end else begin
            tvalid <= beat_in;
            tlast  <= beat_in && last_in;
            fsync  <= beat_in && first_in;
            if (beat_in) tdata <= widen_rgb(sample_in);
        end
    end

    // Latch any beat that the sink did not accept.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lost_beat <= 1'b0;
        else if (tvalid && !sink_ready) lost_beat <= 1'b1;
    end

    // R2: beats are never adjacent because each needs two bytes.
    p_tvalid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid |=> !tvalid);

    // R4: the line-end marker rides only on a valid beat.
    p_tlast_with_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlast |-> tvalid);

    // R5: the frame-start marker rides only on a valid beat.
    p_fsync_with_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> tvalid);

    // R8: a stalled beat raises the flag on the next edge.
    p_overflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !sink_ready) |=> lost_beat);

    // R8: the flag stays until reset.
    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_beat |=> lost_beat);

endmodule

// File: rtl/cam_axis_bridge.sv
// Module: top of the camera-to-stream bridge. Pairs sensor bytes,
// widens them to 32-bit words and streams them with line-end and
// frame-start markers. Runs freely on the sensor clock; never stalls.
module cam_axis_bridge
    import cam_stream_pkg::*;
#(
    parameter int LINE_PIXELS = 640
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cam_vsync,
    input  logic        cam_href,
    input  logic [7:0]  cam_data,
    input  logic        m_tready,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    output logic        m_tlast,
    output logic        m_fsync,
    output logic        overflow
);

    logic    restart;
    logic    pair_ready;
    rgb565_t pair_data;
    logic    line_end;
    logic    frame_start;

    cam_byte_pairer u_pairer (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (cam_href),
        .restart     (restart),
        .byte_in     (cam_data),
        .pair_ready  (pair_ready),
        .pair_data   (pair_data)
    );

    cam_line_tracker #(
        .LINE_PIXELS (LINE_PIXELS)
    ) u_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .vsync_in       (cam_vsync),
        .pixel_done     (pair_ready),
        .frame_restart  (restart),
        .at_line_end    (line_end),
        .at_frame_start (frame_start)
    );

    cam_stream_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_in    (pair_ready),
        .sample_in  (pair_data),
        .last_in    (line_end),
        .first_in   (frame_start),
        .sink_ready (m_tready),
        .tdata      (m_tdata),
        .tvalid     (m_tvalid),
        .tlast      (m_tlast),
        .fsync      (m_fsync),
        .lost_beat  (overflow)
    );

endmodule

// File: tb/cam_axis_bridge_tb_top.sv
module cam_axis_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_PIX   = 4;
    localparam int NVEC       = 8;

    // {high byte, low byte, expected word, expected tlast, expected fsync}
    localparam logic [49:0] VECS [NVEC] = '{
        {8'hFF, 8'hFF, 32'h00F8FCF8, 1'b0, 1'b1},
        {8'h00, 8'h00, 32'h00000000, 1'b0, 1'b0},
        {8'hF8, 8'h00, 32'h00F80000, 1'b0, 1'b0},
        {8'h07, 8'hE0, 32'h0000FC00, 1'b1, 1'b0},
        {8'h00, 8'h1F, 32'h000000F8, 1'b0, 1'b0},
        {8'hA5, 8'h5A, 32'h00A0A8D0, 1'b0, 1'b0},
        {8'h12, 8'h34, 32'h001044A0, 1'b0, 1'b0},
        {8'h08, 8'h41, 32'h00080808, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_vsync = 1'b0;
    logic        cam_href = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        m_tready = 1'b1;
    logic [31:0] m_tdata;
    logic        m_tvalid, m_tlast, m_fsync, overflow;

    int total = 0;
    int bad   = 0;

    logic        mid_valid;
    logic [31:0] got_data;
    logic        got_valid, got_last, got_fsync;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_axis_bridge #(.LINE_PIXELS(LINE_PIX)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cam_vsync (cam_vsync),
        .cam_href  (cam_href),
        .cam_data  (cam_data),
        .m_tready  (m_tready),
        .m_tdata   (m_tdata),
        .m_tvalid  (m_tvalid),
        .m_tlast   (m_tlast),
        .m_fsync   (m_fsync),
        .overflow  (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench at a falling edge.
    task automatic send_pixel(input logic [7:0] hi, input logic [7:0] lo);
        cam_href = 1'b1;
        cam_data = hi;
        @(negedge clk);
        mid_valid = m_tvalid;
        cam_data  = lo;
        @(negedge clk);
        got_valid = m_tvalid;
        got_data  = m_tdata;
        got_last  = m_tlast;
        got_fsync = m_fsync;
    endtask

    task automatic idle(input int n);
        cam_href = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic vsync_pulse();
        cam_href  = 1'b0;
        cam_vsync = 1'b1;
        @(negedge clk);
        cam_vsync = 1'b0;
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cam_data = 8'h5A;
        cam_href = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state even with bytes on the bus
        chk("R1 tvalid", {31'b0, m_tvalid}, 32'd0);
        chk("R1 tdata", m_tdata, 32'd0);
        chk("R1 flags", {29'b0, m_tlast, m_fsync, overflow}, 32'd0);
        cam_href = 1'b0;
        rst_n = 1'b1;
        idle(2);

        vsync_pulse();
        // Table walk: R2, R3, R4, R5 over two lines of one frame
        for (int i = 0; i < NVEC; i++) begin
            send_pixel(VECS[i][49:42], VECS[i][41:34]);
            chk("R2 no beat after first byte", {31'b0, mid_valid}, 32'd0);
            chk("R2 beat after second byte", {31'b0, got_valid}, 32'd1);
            chk("R3 word", got_data, VECS[i][33:2]);
            chk("R4 tlast", {31'b0, got_last}, {31'b0, VECS[i][1]});
            chk("R5 fsync", {31'b0, got_fsync}, {31'b0, VECS[i][0]});
            if (i == 3) begin
                idle(1);
                chk("R2 single-cycle beat", {31'b0, m_tvalid}, 32'd0);
                idle(1);
            end
        end
        idle(2);
        chk("R8 no overflow while ready", {31'b0, overflow}, 32'd0);

        // R6: frame sync mid-line restarts the pixel count
        send_pixel(8'h11, 8'h22);
        send_pixel(8'h33, 8'h44);
        chk("R4 no tlast on 2nd pixel", {31'b0, got_last}, 32'd0);
        idle(1);
        vsync_pulse();
        for (int k = 0; k < LINE_PIX; k++) begin
            send_pixel(8'h12, 8'h34);
            chk("R5 fsync only first", {31'b0, got_fsync}, (k == 0) ? 32'd1 : 32'd0);
            chk("R6 tlast after restart", {31'b0, got_last},
                (k == LINE_PIX - 1) ? 32'd1 : 32'd0);
        end

        // R7: half-received pair is dropped when the qualifier falls
        cam_href = 1'b1;
        cam_data = 8'hAA;
        @(negedge clk);
        idle(2);
        chk("R7 no beat from half pair", {31'b0, m_tvalid}, 32'd0);
        send_pixel(8'hA5, 8'h5A);
        chk("R7 pair realigned", got_data, 32'h00A0A8D0);

        // R8: stalled sink does not hold the beat; flag is sticky
        idle(1);
        m_tready = 1'b0;
        send_pixel(8'h07, 8'hE0);
        chk("R8 beat issued while stalled", {31'b0, got_valid}, 32'd1);
        chk("R8 data while stalled", got_data, 32'h0000FC00);
        chk("R8 flag not yet set", {31'b0, overflow}, 32'd0);
        idle(1);
        chk("R8 beat dropped not held", {31'b0, m_tvalid}, 32'd0);
        chk("R8 flag set", {31'b0, overflow}, 32'd1);
        m_tready = 1'b1;
        idle(3);
        chk("R8 flag sticky", {31'b0, overflow}, 32'd1);

        // R1: reset clears the sticky flag
        rst_n = 1'b0;
        idle(1);
        chk("R1 flag cleared by reset", {31'b0, overflow}, 32'd0);
        rst_n = 1'b1;
        idle(1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule